// File: doc/BRIEF.md
# Memory-Type Change Flush Window Generator

After a write to one of the memory-type configuration registers has been accepted, this block works out which span of physical addresses may now hold stale cached translations. It raises one flush request toward a downstream invalidation port. The request is a half-open window of page frame numbers, `[start, end)`, where frame = byte address >> 12. The block does not perform the flush and does not judge whether the write was legal.

Each cycle the caller presents a register selector and the post-write state. That state is the global and fixed-range enables and the base and mask of the variable pair the write touched. Two system qualifiers come with it: nested paging active, and a non-coherent DMA agent present. The window depends on the register class:
- a fixed-range register flushes its own slice of the first megabyte;
- the default-type register flushes the whole address space;
- a variable pair flushes the span its base and mask describe.

The result is registered and held under a valid/ready handshake. Further flush-producing writes that arrive while a request is still waiting are folded into it, so the pending window widens to cover both and no flush is lost.

Top module: `invrange_top`

## Requirements
- R1: After reset `inv_valid` is 0.
- R2: No request results from a write to the page-attribute selector (0x31), nor from any write while `nested_on` is 0 or `ncdma_present` is 0.
- R3: While `glob_en` is 0, only a default-type write (selector 0x30) produces a request.
- R4: A fixed-range write (selectors 0x20 to 0x2A) produces a request only while both `glob_en` and `fix_en` are 1.
- R5: Fixed selectors cover three segments, each unit 8 sub-ranges wide, with frames in hex. Selector 0x20 flushes 0x00–0x80, a single unit of 64 KiB sub-ranges. Selectors 0x21 and 0x22 are two units of 16 KiB sub-ranges from frame 0x80, 0x20 frames each. Selectors 0x23 to 0x2A are eight units of 4 KiB sub-ranges from frame 0xC0, 8 frames each.
- R6: A default-type write flushes start frame 0 to end frame all-ones (PFN_W bits, top bit of `inv_end_pfn` 0).
- R7: Selectors 0 to 2*NVAR-1 address variable pairs, with even selectors for the base and odd ones for the mask. Both flush start = base >> 12 and end = ((base >> 12) | ~(mask >> 12)) + 1, ignoring the low 12 bits of both. Selectors from 2*NVAR up to 0x1F, and 0x2B to 0x2F, produce no request.
- R8: When the variable end wraps past the top address (mask frame bits all 0), `inv_end_pfn` equals 2^PFN_W.
- R9: A request appears on the clock edge that samples the write. It stays valid with unchanged frames until `inv_ready` is 1.
- R10: With `inv_ready` 1 and no new request, `inv_valid` falls on the next edge. A request that arrives in the same cycle as `inv_ready` replaces the old window outright.
- R11: A request that arrives while one is held and `inv_ready` is 0 widens the held window to the smallest start and the largest end of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | An accepted configuration write is present |
| wr_sel | input | 6 | Selector of the written register |
| glob_en | input | 1 | Global memory-type enable (post-write) |
| fix_en | input | 1 | Fixed-range enable (post-write) |
| var_base | input | ADDR_W | Base of the affected variable pair |
| var_mask | input | ADDR_W | Mask of the affected variable pair |
| nested_on | input | 1 | Nested paging active |
| ncdma_present | input | 1 | A non-coherent DMA agent exists |
| inv_ready | input | 1 | Invalidation port accepts the request |
| inv_valid | output | 1 | Flush request pending |
| inv_start_pfn | output | ADDR_W-12 | First frame to flush |
| inv_end_pfn | output | ADDR_W-11 | Frame one past the last to flush |

## Verification
The case that is hardest to reach from the ports is window merging. It needs a request already held with `inv_ready` low, then a second qualifying write in the very next cycle, before the port drains. The directed stimulus drops `inv_ready`, issues a fixed unit at frame 0xC0 and then the 64 KiB unit at frame 0. It checks the hull 0x00–0xC8, then shows that a non-qualifying write leaves the hull untouched. The overflowing variable end, at the all-zero mask, sits in the vector table.

// File: rtl/invrange_pkg.sv
package invrange_pkg;

    localparam int SEL_W = 6;

    localparam logic [SEL_W-1:0] SEL_FIX_FIRST = 6'h20;
    localparam logic [SEL_W-1:0] SEL_DEFTYPE   = 6'h30;
    localparam logic [SEL_W-1:0] SEL_PAGEATTR  = 6'h31;

    localparam int FIX_SEGS = 3;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_VAR,
        CLS_FIXED,
        CLS_DEFTYPE,
        CLS_PAGEATTR
    } reg_class_e;

    typedef struct packed {
        reg_class_e cls;
        logic [1:0] seg;
        logic [2:0] unit;
    } reg_decode_t;

    // number of 8-sub-range units in a fixed segment
    function automatic int fix_seg_units(input int s);
        case (s)
            0:       return 1;
            1:       return 2;
            default: return 8;
        endcase
    endfunction

    // selector offset (from SEL_FIX_FIRST) of a segment's first unit
    function automatic int fix_seg_first(input int s);
        int acc = 0;
        for (int k = 0; k < s; k++) acc += fix_seg_units(k);
        return acc;
    endfunction

    // first frame of a segment
    function automatic logic [7:0] fix_seg_start_pfn(input int s);
        case (s)
            0:       return 8'h00;
            1:       return 8'h80;
            default: return 8'hC0;
        endcase
    endfunction

    // frames per unit: 8 sub-ranges of 64K, 16K, 4K -> 8 << (4 - 2*s)
    function automatic logic [7:0] fix_unit_pfn(input int s);
        return 8'(8 << (4 - 2 * s));
    endfunction

endpackage

// File: rtl/invrange_decode.sv
module invrange_decode
    import invrange_pkg::*;
#(
    parameter int NVAR = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             glob_en,
    input  logic             fix_en,
    input  logic             nested_on,
    input  logic             ncdma_present,
    output reg_decode_t      dec,
    output logic             issue
);
    localparam int VAR_SELS = 2 * NVAR;

    logic path_ok;
    logic class_ok;

    always_comb begin
        int off_i;
        dec   = '{cls: CLS_NONE, seg: 2'd0, unit: 3'd0};
        off_i = int'(wr_sel) - int'(SEL_FIX_FIRST);
        if (int'(wr_sel) < VAR_SELS) begin
            dec.cls = CLS_VAR;
        end else if (wr_sel == SEL_DEFTYPE) begin
            dec.cls = CLS_DEFTYPE;
        end else if (wr_sel == SEL_PAGEATTR) begin
            dec.cls = CLS_PAGEATTR;
        end else begin
            for (int s = 0; s < FIX_SEGS; s++) begin
                if (off_i >= fix_seg_first(s) &&
                    off_i < fix_seg_first(s) + fix_seg_units(s)) begin
                    dec.cls  = CLS_FIXED;
                    dec.seg  = 2'(s);
                    dec.unit = 3'(off_i - fix_seg_first(s));
                end
            end
        end
    end

    always_comb begin
        path_ok = nested_on && ncdma_present;
        case (dec.cls)
            CLS_VAR:     class_ok = glob_en;
            CLS_FIXED:   class_ok = glob_en && fix_en;
            CLS_DEFTYPE: class_ok = 1'b1;
            default:     class_ok = 1'b0;
        endcase
        issue = wr_valid && path_ok && class_ok;
    end

    assert_pageattr_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == SEL_PAGEATTR) |-> !issue);
    assert_qualifiers_R2: assert property (@(posedge clk) disable iff (rst)
        issue |-> (nested_on && ncdma_present && wr_valid));
    assert_global_off_R3: assert property (@(posedge clk) disable iff (rst)
        (issue && !glob_en) |-> (wr_sel == SEL_DEFTYPE));
    assert_fixed_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (issue && dec.cls == CLS_FIXED) |-> fix_en);

endmodule

// File: rtl/invrange_window.sv
module invrange_window
    import invrange_pkg::*;
#(
    parameter int ADDR_W = 40,
    localparam int PFN_W = ADDR_W - 12,
    localparam int END_W = PFN_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  reg_decode_t       dec,
    input  logic [ADDR_W-1:0] var_base,
    input  logic [ADDR_W-1:0] var_mask,
    output logic [PFN_W-1:0]  start_pfn,
    output logic [END_W-1:0]  end_pfn
);
    logic [PFN_W-1:0] base_frame;
    logic [PFN_W-1:0] mask_frame;
    logic [PFN_W-1:0] fix_start;
    logic [PFN_W-1:0] fix_len;

    assign base_frame = var_base[ADDR_W-1:12];
    assign mask_frame = var_mask[ADDR_W-1:12];

    always_comb begin
        logic [10:0] prod;
        prod      = 11'(dec.unit) * 11'(fix_unit_pfn(int'(dec.seg)));
        fix_start = PFN_W'(fix_seg_start_pfn(int'(dec.seg))) + PFN_W'(prod);
        fix_len   = PFN_W'(fix_unit_pfn(int'(dec.seg)));
    end

    always_comb begin
        case (dec.cls)
            CLS_VAR: begin
                start_pfn = base_frame;
                end_pfn   = {1'b0, base_frame | ~mask_frame} + END_W'(1);
            end
            CLS_FIXED: begin
                start_pfn = fix_start;
                end_pfn   = {1'b0, fix_start} + {1'b0, fix_len};
            end
            CLS_DEFTYPE: begin
                start_pfn = '0;
                end_pfn   = {1'b0, {PFN_W{1'b1}}};
            end
            default: begin
                start_pfn = '0;
                end_pfn   = '0;
            end
        endcase
    end

    assert_window_order_R7: assert property (@(posedge clk) disable iff (rst)
        issue |-> ({1'b0, start_pfn} < end_pfn));
    assert_fixed_low_mb_R5: assert property (@(posedge clk) disable iff (rst)
        (issue && dec.cls == CLS_FIXED) |-> (end_pfn <= END_W'(256)));

endmodule

// File: rtl/invrange_hold.sv
module invrange_hold #(
    parameter int PFN_W = 28,
    localparam int END_W = PFN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             new_req,
    input  logic [PFN_W-1:0] new_start,
    input  logic [END_W-1:0] new_end,
    input  logic             ready,
    output logic             valid,
    output logic [PFN_W-1:0] start_q,
    output logic [END_W-1:0] end_q
);
    logic merge;
    assign merge = valid && !ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            start_q <= '0;
            end_q   <= '0;
        end else if (new_req) begin
            valid <= 1'b1;
            if (merge) begin
                start_q <= (new_start < start_q) ? new_start : start_q;
                end_q   <= (new_end > end_q) ? new_end : end_q;
            end else begin
                start_q <= new_start;
                end_q   <= new_end;
            end
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && !new_req) |=> (valid && $stable(start_q) && $stable(end_q)));
    assert_drain_R10: assert property (@(posedge clk) disable iff (rst)
        (valid && ready && !new_req) |=> !valid);
    assert_merge_widens_R11: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && new_req) |=>
            (valid && start_q <= $past(start_q) && end_q >= $past(end_q)));
    assert_request_lands_R9: assert property (@(posedge clk) disable iff (rst)
        new_req |=> valid);

endmodule

// File: rtl/invrange_top.sv
module invrange_top
    import invrange_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int NVAR   = 8,
    localparam int PFN_W = ADDR_W - 12,
    localparam int END_W = PFN_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              glob_en,
    input  logic              fix_en,
    input  logic [ADDR_W-1:0] var_base,
    input  logic [ADDR_W-1:0] var_mask,
    input  logic              nested_on,
    input  logic              ncdma_present,
    input  logic              inv_ready,
    output logic              inv_valid,
    output logic [PFN_W-1:0]  inv_start_pfn,
    output logic [END_W-1:0]  inv_end_pfn
);
    reg_decode_t      dec;
    logic             issue;
    logic [PFN_W-1:0] win_start;
    logic [END_W-1:0] win_end;

    invrange_decode #(.NVAR(NVAR)) u_decode (
        .clk           (clk),
        .rst           (rst),
        .wr_valid      (wr_valid),
        .wr_sel        (wr_sel),
        .glob_en       (glob_en),
        .fix_en        (fix_en),
        .nested_on     (nested_on),
        .ncdma_present (ncdma_present),
        .dec           (dec),
        .issue         (issue)
    );

    invrange_window #(.ADDR_W(ADDR_W)) u_window (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .dec       (dec),
        .var_base  (var_base),
        .var_mask  (var_mask),
        .start_pfn (win_start),
        .end_pfn   (win_end)
    );

    invrange_hold #(.PFN_W(PFN_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .new_req   (issue),
        .new_start (win_start),
        .new_end   (win_end),
        .ready     (inv_ready),
        .valid     (inv_valid),
        .start_q   (inv_start_pfn),
        .end_q     (inv_end_pfn)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> !inv_valid);

endmodule

// File: tb/test_invrange_top.sv
`timescale 1ns/1ps
module test_invrange_top;
    localparam int ADDR_W = 40;
    localparam int PFN_W  = ADDR_W - 12;
    localparam int END_W  = PFN_W + 1;
    localparam real HALF  = 2.5;

    typedef struct packed {
        logic [5:0]        sel;
        logic              g;
        logic              f;
        logic              n;
        logic              c;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic              ev;
        logic [PFN_W-1:0]  es;
        logic [END_W-1:0]  ee;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 24;
    localparam logic [ADDR_W-1:0] M4K = 40'hFF_FFFF_F800;
    localparam logic [ADDR_W-1:0] M1M = 40'hFF_FFF0_0800;
    localparam logic [END_W-1:0]  ALL = {1'b0, {PFN_W{1'b1}}};

    localparam vec_t VECS [NV] = '{
        // R7 variable base / mask selectors, low 12 bits ignored
        '{6'h00, 1'b1, 1'b0, 1'b1, 1'b1, 40'h00_1234_5678, M4K, 1'b1, 28'h12345, 29'h12346, 4'd7},
        '{6'h01, 1'b1, 1'b0, 1'b1, 1'b1, 40'h00_1234_5678, M4K, 1'b1, 28'h12345, 29'h12346, 4'd7},
        '{6'h0E, 1'b1, 1'b1, 1'b1, 1'b1, 40'h00_0010_0006, M1M, 1'b1, 28'h00100, 29'h00200, 4'd7},
        '{6'h07, 1'b1, 1'b0, 1'b1, 1'b1, 40'h00_8000_0FFF, 40'hFF_C000_0FFF, 1'b1, 28'h80000, 29'hC0000, 4'd7},
        // R8 wrap of the variable end
        '{6'h0F, 1'b1, 1'b0, 1'b1, 1'b1, 40'h0, 40'h0, 1'b1, 28'h0, 29'h1000_0000, 4'd8},
        '{6'h02, 1'b1, 1'b0, 1'b1, 1'b1, 40'hFF_FFFF_F000, 40'hFF_FFFF_F000, 1'b1, 28'hFFF_FFFF, 29'h1000_0000, 4'd8},
        // R5 fixed segments
        '{6'h20, 1'b1, 1'b1, 1'b1, 1'b1, 40'h0, 40'h0, 1'b1, 28'h00, 29'h080, 4'd5},
        '{6'h21, 1'b1, 1'b1, 1'b1, 1'b1, 40'h0, 40'h0, 1'b1, 28'h80, 29'h0A0, 4'd5},
        '{6'h22, 1'b1, 1'b1, 1'b1, 1'b1, 40'h0, 40'h0, 1'b1, 28'hA0, 29'h0C0, 4'd5},
        '{6'h23, 1'b1, 1'b1, 1'b1, 1'b1, 40'h0, 40'h0, 1'b1, 28'hC0, 29'h0C8, 4'd5},
        '{6'h26, 1'b1, 1'b1, 1'b1, 1'b1, 40'h0, 40'h0, 1'b1, 28'hD8, 29'h0E0, 4'd5},
        '{6'h2A, 1'b1, 1'b1, 1'b1, 1'b1, 40'h0, 40'h0, 1'b1, 28'hF8, 29'h100, 4'd5},
        // R4 fixed without fixed enable
        '{6'h25, 1'b1, 1'b0, 1'b1, 1'b1, 40'h0, 40'h0, 1'b0, 28'h0, 29'h0, 4'd4},
        // R6 default type, enabled and disabled globally
        '{6'h30, 1'b1, 1'b0, 1'b1, 1'b1, 40'h0, 40'h0, 1'b1, 28'h0, ALL, 4'd6},
        '{6'h30, 1'b0, 1'b0, 1'b1, 1'b1, 40'h0, 40'h0, 1'b1, 28'h0, ALL, 4'd6},
        // R3 global enable clear
        '{6'h00, 1'b0, 1'b1, 1'b1, 1'b1, 40'h00_1234_5000, M4K, 1'b0, 28'h0, 29'h0, 4'd3},
        '{6'h20, 1'b0, 1'b1, 1'b1, 1'b1, 40'h0, 40'h0, 1'b0, 28'h0, 29'h0, 4'd3},
        // R2 page attribute, qualifiers off
        '{6'h31, 1'b1, 1'b1, 1'b1, 1'b1, 40'h0, 40'h0, 1'b0, 28'h0, 29'h0, 4'd2},
        '{6'h00, 1'b1, 1'b1, 1'b0, 1'b1, 40'h00_1234_5000, M4K, 1'b0, 28'h0, 29'h0, 4'd2},
        '{6'h30, 1'b1, 1'b1, 1'b1, 1'b0, 40'h0, 40'h0, 1'b0, 28'h0, 29'h0, 4'd2},
        '{6'h21, 1'b1, 1'b1, 1'b0, 1'b0, 40'h0, 40'h0, 1'b0, 28'h0, 29'h0, 4'd2},
        // R7 unused selectors
        '{6'h10, 1'b1, 1'b1, 1'b1, 1'b1, 40'h00_1234_5000, M4K, 1'b0, 28'h0, 29'h0, 4'd7},
        '{6'h2B, 1'b1, 1'b1, 1'b1, 1'b1, 40'h0, 40'h0, 1'b0, 28'h0, 29'h0, 4'd7},
        '{6'h3F, 1'b1, 1'b1, 1'b1, 1'b1, 40'h0, 40'h0, 1'b0, 28'h0, 29'h0, 4'd7}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_valid;
    logic [5:0]        wr_sel;
    logic              glob_en, fix_en, nested_on, ncdma_present, inv_ready;
    logic [ADDR_W-1:0] var_base, var_mask;
    logic              inv_valid;
    logic [PFN_W-1:0]  inv_start_pfn;
    logic [END_W-1:0]  inv_end_pfn;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(HALF) clk = ~clk;

    invrange_top #(.ADDR_W(ADDR_W), .NVAR(8)) i_invrange_top (
        .clk           (clk),
        .rst           (rst),
        .wr_valid      (wr_valid),
        .wr_sel        (wr_sel),
        .glob_en       (glob_en),
        .fix_en        (fix_en),
        .var_base      (var_base),
        .var_mask      (var_mask),
        .nested_on     (nested_on),
        .ncdma_present (ncdma_present),
        .inv_ready     (inv_ready),
        .inv_valid     (inv_valid),
        .inv_start_pfn (inv_start_pfn),
        .inv_end_pfn   (inv_end_pfn)
    );

    task automatic check(input string tag, input logic ev,
                         input logic [PFN_W-1:0] es, input logic [END_W-1:0] ee);
        tests++;
        if (inv_valid !== ev || (ev && (inv_start_pfn !== es || inv_end_pfn !== ee))) begin
            fails++;
            $display("FAIL %s: valid=%0b start=%h end=%h expected valid=%0b start=%h end=%h",
                     tag, inv_valid, inv_start_pfn, inv_end_pfn, ev, es, ee);
        end
    endtask

    task automatic drive(input logic [5:0] sel, input logic g, input logic f,
                         input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] m);
        wr_valid = 1'b1; wr_sel = sel; glob_en = g; fix_en = f;
        var_base = b; var_mask = m; nested_on = 1'b1; ncdma_present = 1'b1;
    endtask

    initial begin
        rst = 1'b1; wr_valid = 1'b0; wr_sel = '0; glob_en = 1'b0; fix_en = 1'b0;
        var_base = '0; var_mask = '0; nested_on = 1'b1; ncdma_present = 1'b1;
        inv_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, '0, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset release", 1'b0, '0, '0);

        // table walk, ready held high
        for (int i = 0; i < NV; i++) begin
            wr_valid = 1'b1; wr_sel = VECS[i].sel; glob_en = VECS[i].g; fix_en = VECS[i].f;
            nested_on = VECS[i].n; ncdma_present = VECS[i].c;
            var_base = VECS[i].base; var_mask = VECS[i].mask;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].ev, VECS[i].es, VECS[i].ee);
            wr_valid = 1'b0;
            @(negedge clk);
        end

        // R9 hold until ready
        inv_ready = 1'b0;
        drive(6'h21, 1'b1, 1'b1, '0, '0);
        @(negedge clk);
        check("R9 request after one edge", 1'b1, 28'h80, 29'h0A0);
        wr_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 held without ready", 1'b1, 28'h80, 29'h0A0);
        // R10 drain
        inv_ready = 1'b1;
        @(negedge clk);
        check("R10 drained after ready", 1'b0, '0, '0);

        // R11 merge
        inv_ready = 1'b0;
        drive(6'h23, 1'b1, 1'b1, '0, '0);
        @(negedge clk);
        check("R11 first request", 1'b1, 28'hC0, 29'h0C8);
        drive(6'h20, 1'b1, 1'b1, '0, '0);
        @(negedge clk);
        check("R11 merged hull", 1'b1, 28'h00, 29'h0C8);
        drive(6'h31, 1'b1, 1'b1, '0, '0);
        @(negedge clk);
        check("R2 page attribute leaves held window", 1'b1, 28'h00, 29'h0C8);
        drive(6'h00, 1'b1, 1'b1, 40'h00_0010_0000, M1M);
        @(negedge clk);
        check("R11 merge with variable window", 1'b1, 28'h00, 29'h200);
        // R10 replacement on ready
        inv_ready = 1'b1;
        drive(6'h2A, 1'b1, 1'b1, '0, '0);
        @(negedge clk);
        check("R10 replace on ready", 1'b1, 28'hF8, 29'h100);
        wr_valid = 1'b0;
        @(negedge clk);
        check("R10 idle after replacement drained", 1'b0, '0, '0);

        // R1 reset mid-request
        inv_ready = 1'b0;
        drive(6'h30, 1'b0, 1'b0, '0, '0);
        @(negedge clk);
        wr_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears held request", 1'b0, '0, '0);
        rst = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(2.0 * HALF * 200000.0);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule